// File: doc/BRIEF.md
# Pulse-by-Pulse Switch Fault and Current-Limit Supervisor

This block sits between a PWM generator and the gate drivers of a three-phase bridge plus a braking switch. Each switch has an on-command bit and two digital flags from external comparators: a short-circuit trip and a current-limit flag. A short-circuit trip on a conducting phase switch turns off that switch alone and pulls a shared active-low fault line low. A current-limit flag pulls a shared active-low warning line low. Neither is sticky across pulses: each switch's latches clear when that switch receives its next on-command, so protection works pulse by pulse without any global clear.

The block also times the sampling of a phase-current measurement. Every new on-command of a phase switch starts a delay; when it expires a read-valid strobe rises and stays high for a bounded hold window, after which the held data must be treated as stale. Both durations are parameters in clock cycles.

Top module: `pulse_guard`

## Requirements
- R1: During and directly after reset all gate outputs are 0, `faultN` and `clWarnN` are 1 and `readValid` is 0.
- R2: Bit i of every per-switch vector belongs to switch i, commands are active high, and with no trip latched `gateOut[i]` equals the `cmdOn[i]` value sampled at the previous rising clock edge.
- R3: A `scTrip[i]` sampled while `gateOut[i]` is 1, for a phase switch, turns `gateOut[i]` off at that same edge and keeps it off while the command stays on; gates of the other switches are unaffected.
- R4: `faultN` is low from the edge a phase-switch trip is latched and returns high at the edge where no trip latch remains set.
- R5: A trip latch clears at the edge where that switch's command is first sampled high after being low, and its gate turns on at that edge; a trip flag sampled in that same cycle is ignored because the gate was still off.
- R6: A trip flag sampled while the switch's gate is off has no effect on gates or `faultN`.
- R7: The brake switch (index `BRAKE_IDX`, default 6) is excluded: its trip flag never turns its gate off and never drives `faultN`.
- R8: A `clFlag[i]` sampled on a phase switch pulls `clWarnN` low at that edge; it stays low until every flagged switch has seen a command rise, a flag sampled in the rise cycle keeps its own latch set, and the brake's flag is ignored.
- R9: A command rise of any phase switch sampled at edge k makes `readValid` 1 from edge k+`READ_DLY` for exactly `HOLD_WIN` cycles, then 0.
- R10: A new phase-switch command rise restarts the read sequence from that edge, dropping `readValid` at once if high; a rise of the brake command does not start it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdOn | input | NUM_SW | On-command per switch, active high |
| scTrip | input | NUM_SW | Short-circuit comparator flag per switch |
| clFlag | input | NUM_SW | Current-limit comparator flag per switch |
| gateOut | output | NUM_SW | Registered gate enable per switch |
| faultN | output | 1 | Registered short-circuit fault, active low |
| clWarnN | output | 1 | Registered current-limit warning, active low |
| readValid | output | 1 | Current data may be sampled while high |

## Verification
The hardest case is a trip or limit flag landing in the very cycle its switch's command rises, where the clear and the set meet on one edge with opposite outcomes for the two latch kinds. The bench reaches it by holding every command off, then raising a command and a flag together, once per switch index, and comparing gates and both shared outputs at that edge. The read timer's restart is reached by a sweep that drops a second phase rise at many offsets into both the wait and hold windows of a first one.

// File: rtl/pulse_guard_pkg.sv
package pulse_guard_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_HOLD = 2'd2
  } phase_e;

  // Strobes from the read-timer control into the datapath counter.
  typedef struct packed {
    logic startWait;
    logic startHold;
    logic stopHold;
    logic tick;
  } timerCmd_t;

endpackage

// File: rtl/pulse_guard_ctrl.sv
module pulse_guard_ctrl
  import pulse_guard_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      trigger,
  input  logic      cntZero,
  output timerCmd_t tcmd
);

  phase_e phase, phaseNext;

  always_comb begin
    phaseNext = phase;
    tcmd      = '0;
    if (trigger) begin
      phaseNext      = PH_WAIT;
      tcmd.startWait = 1'b1;
    end else begin
      unique case (phase)
        PH_WAIT: begin
          if (cntZero) begin
            phaseNext      = PH_HOLD;
            tcmd.startHold = 1'b1;
          end else begin
            tcmd.tick = 1'b1;
          end
        end
        PH_HOLD: begin
          if (cntZero) begin
            phaseNext     = PH_IDLE;
            tcmd.stopHold = 1'b1;
          end else begin
            tcmd.tick = 1'b1;
          end
        end
        default: phaseNext = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

endmodule

// File: rtl/pulse_guard_dp.sv
module pulse_guard_dp
  import pulse_guard_pkg::*;
#(
  parameter int NUM_SW    = 7,
  parameter int BRAKE_IDX = 6,
  parameter int READ_DLY  = 8,
  parameter int HOLD_WIN  = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_SW-1:0] cmdOn,
  input  logic [NUM_SW-1:0] scTrip,
  input  logic [NUM_SW-1:0] clFlag,
  input  timerCmd_t         tcmd,
  output logic [NUM_SW-1:0] gateOut,
  output logic              faultN,
  output logic              clWarnN,
  output logic              readValid,
  output logic              trigger,
  output logic              cntZero
);

  localparam int MAX_WIN = (READ_DLY > HOLD_WIN) ? READ_DLY : HOLD_WIN;
  localparam int CNT_W   = $clog2(MAX_WIN + 1);
  localparam logic [NUM_SW-1:0] PHASE_MASK = ~(NUM_SW'(1) << BRAKE_IDX);

  logic [NUM_SW-1:0] prevCmd, rise;
  logic [NUM_SW-1:0] tripLat, tripNext;
  logic [NUM_SW-1:0] clLat, clNext;
  logic [CNT_W-1:0]  cnt;

  for (genvar i = 0; i < NUM_SW; i++) begin : g_sw
    assign rise[i] = cmdOn[i] & ~prevCmd[i];

    if (i == BRAKE_IDX) begin : g_brake
      assign tripNext[i] = 1'b0;
      assign clNext[i]   = 1'b0;
    end else begin : g_phase
      // a trip only counts while the gate is actually conducting
      assign tripNext[i] = rise[i] ? 1'b0
                                   : (tripLat[i] | (scTrip[i] & gateOut[i]));
      // a limit flag present in the rise cycle survives the clear
      assign clNext[i]   = rise[i] ? clFlag[i] : (clLat[i] | clFlag[i]);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prevCmd[i] <= 1'b0;
        tripLat[i] <= 1'b0;
        clLat[i]   <= 1'b0;
        gateOut[i] <= 1'b0;
      end else begin
        prevCmd[i] <= cmdOn[i];
        tripLat[i] <= tripNext[i];
        clLat[i]   <= clNext[i];
        gateOut[i] <= cmdOn[i] & ~tripNext[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultN  <= 1'b1;
      clWarnN <= 1'b1;
    end else begin
      faultN  <= ~|tripNext;
      clWarnN <= ~|clNext;
    end
  end

  assign trigger = |(rise & PHASE_MASK);
  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      readValid <= 1'b0;
    end else begin
      if (tcmd.startWait) begin
        cnt       <= CNT_W'(READ_DLY - 1);
        readValid <= 1'b0;
      end else if (tcmd.startHold) begin
        cnt       <= CNT_W'(HOLD_WIN - 1);
        readValid <= 1'b1;
      end else if (tcmd.stopHold) begin
        readValid <= 1'b0;
      end else if (tcmd.tick) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/pulse_guard.sv
module pulse_guard
  import pulse_guard_pkg::*;
#(
  parameter int NUM_SW    = 7,
  parameter int BRAKE_IDX = 6,
  parameter int READ_DLY  = 8,
  parameter int HOLD_WIN  = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_SW-1:0] cmdOn,
  input  logic [NUM_SW-1:0] scTrip,
  input  logic [NUM_SW-1:0] clFlag,
  output logic [NUM_SW-1:0] gateOut,
  output logic              faultN,
  output logic              clWarnN,
  output logic              readValid
);

  timerCmd_t tcmd;
  logic      trigger, cntZero;

  pulse_guard_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .trigger (trigger),
    .cntZero (cntZero),
    .tcmd    (tcmd)
  );

  pulse_guard_dp #(
    .NUM_SW    (NUM_SW),
    .BRAKE_IDX (BRAKE_IDX),
    .READ_DLY  (READ_DLY),
    .HOLD_WIN  (HOLD_WIN)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmdOn     (cmdOn),
    .scTrip    (scTrip),
    .clFlag    (clFlag),
    .tcmd      (tcmd),
    .gateOut   (gateOut),
    .faultN    (faultN),
    .clWarnN   (clWarnN),
    .readValid (readValid),
    .trigger   (trigger),
    .cntZero   (cntZero)
  );

endmodule

// File: rtl/pulse_guard_chk.sv
module pulse_guard_chk #(
  parameter int NUM_SW    = 7,
  parameter int BRAKE_IDX = 6,
  parameter int HOLD_WIN  = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_SW-1:0] cmdOn,
  input logic [NUM_SW-1:0] scTrip,
  input logic [NUM_SW-1:0] clFlag,
  input logic [NUM_SW-1:0] gateOut,
  input logic              faultN,
  input logic              clWarnN,
  input logic              readValid
);

  localparam logic [NUM_SW-1:0] PHASE_MASK = ~(NUM_SW'(1) << BRAKE_IDX);

  int unsigned hiCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          hiCnt <= 0;
    else if (readValid) hiCnt <= hiCnt + 1;
    else                hiCnt <= 0;
  end

  for (genvar i = 0; i < NUM_SW; i++) begin : g_chk
    // R2
    gate_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
      gateOut[i] |-> $past(cmdOn[i]));

    if (i == BRAKE_IDX) begin : g_brk
      // R7
      brake_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
        gateOut[i] == $past(cmdOn[i]));
    end else begin : g_ph
      // R3
      trip_cuts_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
        (gateOut[i] && scTrip[i]) |=> (!gateOut[i] && !faultN));
    end
  end

  // R4
  fault_needs_live_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(faultN) |-> |($past(gateOut) & PHASE_MASK));

  // R8
  warn_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clWarnN) |-> |($past(clFlag) & PHASE_MASK));

  // R9
  hold_window_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    readValid |-> (hiCnt < HOLD_WIN));

endmodule

bind pulse_guard pulse_guard_chk #(
  .NUM_SW    (NUM_SW),
  .BRAKE_IDX (BRAKE_IDX),
  .HOLD_WIN  (HOLD_WIN)
) u_chk (.*);

// File: tb/pulse_guard_tb.sv
module pulse_guard_tb;

  localparam int NSW = 7;
  localparam int BRK = 6;
  localparam int DLY = 8;
  localparam int HLD = 20;
  localparam logic [NSW-1:0] ALL = '1;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [NSW-1:0] cmd = '0, sc = '0, cl = '0;
  logic [NSW-1:0] gateOut;
  logic           faultN, clWarnN, readValid;
  int             total = 0, bad = 0;
  bit             done = 0;

  always #2 clk = ~clk;

  pulse_guard #(.NUM_SW(NSW), .BRAKE_IDX(BRK), .READ_DLY(DLY), .HOLD_WIN(HLD)) u_dut (
    .clk(clk), .rstN(rstN), .cmdOn(cmd), .scTrip(sc), .clFlag(cl),
    .gateOut(gateOut), .faultN(faultN), .clWarnN(clWarnN), .readValid(readValid)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    cmd = '0; sc = '0; cl = '0;
    repeat (DLY + HLD + 3) tick();
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) tick();
    chk("R1 gate", gateOut, 0);
    chk("R1 fault", faultN, 1);
    chk("R1 warn", clWarnN, 1);
    chk("R1 rv", readValid, 0);
    rstN = 1'b1;
    tick();
    chk("R1 gate after release", gateOut, 0);

    // per-switch short-circuit sweep
    for (int i = 0; i < NSW; i++) begin
      logic [NSW-1:0] cut;
      cut = (i == BRK) ? '0 : NSW'(1) << i;
      cmd = ALL; tick();
      chk("R2 gate follows cmd", gateOut, ALL);
      sc = NSW'(1) << i; tick(); sc = '0;
      chk("R3 only offender off", gateOut, ALL & ~cut);
      chk(i == BRK ? "R7 brake no fault" : "R4 fault low", faultN, (i == BRK));
      tick();
      chk("R3 held off", gateOut, ALL & ~cut);
      cmd = '0; tick();
      chk("R2 gates off", gateOut, 0);
      chk("R4 latch persists", faultN, (i == BRK));
      cmd = ALL; sc = NSW'(1) << i; tick(); sc = '0;
      chk("R5 rise clears gate", gateOut, ALL);
      chk("R5 rise clears fault", faultN, 1);
      cmd = '0; tick();
    end

    // R6 trip while gates off
    sc = ALL; tick(); tick();
    chk("R6 fault unaffected", faultN, 1);
    chk("R6 gates off", gateOut, 0);
    sc = '0; cmd = ALL; tick();
    chk("R6 gates on after", gateOut, ALL);
    chk("R6 fault still high", faultN, 1);
    cmd = '0; tick();

    // R8 current-limit sweep
    for (int i = 0; i < NSW; i++) begin
      cl = NSW'(1) << i; tick(); cl = '0;
      chk(i == BRK ? "R8 brake flag ignored" : "R8 warn low", clWarnN, (i == BRK));
      tick();
      chk("R8 warn held", clWarnN, (i == BRK));
      cmd = NSW'(1) << i; cl = NSW'(1) << i; tick(); cl = '0;
      chk("R8 flag in rise cycle kept", clWarnN, (i == BRK));
      cmd = '0; tick();
      cmd = NSW'(1) << i; tick();
      chk("R8 rise clears warn", clWarnN, 1);
      cmd = '0; tick();
    end
    cl = 7'b0000011; tick(); cl = '0;
    cmd = 7'b0000001; tick();
    chk("R8 other switch still warns", clWarnN, 0);
    cmd = 7'b0000011; tick();
    chk("R8 all cleared", clWarnN, 1);

    // R9 single read sequence
    idle();
    cmd = 7'b0000001; tick();
    for (int t = 0; t <= DLY + HLD + 1; t++) begin
      chk("R9 readValid window", readValid, (t >= DLY && t < DLY + HLD));
      tick();
    end

    // R10 restart sweep
    for (int r = 1; r < DLY + HLD; r += 3) begin
      idle();
      cmd = 7'b0000001; tick();
      repeat (r - 1) tick();
      cmd = 7'b0000011; tick();
      for (int t = 0; t <= DLY + HLD + 1; t++) begin
        chk("R10 restart window", readValid, (t >= DLY && t < DLY + HLD));
        tick();
      end
    end

    // R10 brake rise is no trigger
    idle();
    cmd = NSW'(1) << BRK; tick();
    for (int t = 0; t <= DLY + HLD; t++) begin
      chk("R10 brake no trigger", readValid, 0);
      tick();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule